// File: doc/BRIEF.md
# Indexed Configuration Access Port with Per-Read Unlock

This block opens a narrow I/O window onto a byte-wide configuration register file. Software sees three consecutive byte ports: an index port, a key port and a data port, starting at a parameterized base address (0x22 by default). It selects a register by writing its number to the index port. It then proves intent by writing the index back with its two nibbles exchanged to the key port. That unlocks exactly one read of the selected register through the data port.

The unlock is consumed by that one read, or by any write to the data port. Every further access needs a fresh key. The block drives the register file's read address from the stored index and takes the read data back in the same cycle. It never writes into the register file. Reads of the data port while locked, and reads of any address outside the three ports, return all ones.

Top module: `cfg_index_port`

## Requirements
- R1: A write to the index port (BASE+0) stores io_wdata as the index on that clock edge. A read of the index port returns the stored index, and rf_addr always equals the stored index.
- R2: A write to the key port (BASE+1) sets the unlock flag when io_wdata equals the stored index with its upper and lower nibbles exchanged. Any other written value leaves the flag as it was, whether set or clear.
- R3: A read of the key port returns the stored index with its upper and lower nibbles exchanged.
- R4: While unlocked, a read of the data port (BASE+2) returns rf_rdata, which is the register at the stored index, and clears the unlock flag. A second read without a new key returns 0xFF.
- R5: While locked, a read of the data port returns 0xFF.
- R6: A write to the data port clears the unlock flag and changes nothing else. The index is kept.
- R7: A read of any address other than the three ports returns 0xFF. A write to such an address changes neither the index nor the unlock flag.
- R8: A synchronous active-high reset clears the index to 0x00 and the unlock flag to 0.
- R9: The index and the flag change only on the clock edge that samples a strobe. io_rdata is combinational from the state before that edge. Writing a new index does not clear the unlock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_wdata | input | DATA_W | Host write data |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_rdata | output | DATA_W | Read data for the addressed port, combinational |
| rf_addr | output | DATA_W | Register file read address (the stored index) |
| rf_rdata | input | DATA_W | Register file read data for rf_addr, same cycle |

## Verification
The hardest state to reach from the ports is an unlock that survives a stimulus which should leave it alone. Examples are a wrong key written while already unlocked, a write to an unrelated address, and a new index written after the key. The flag itself is not visible at the ports. So the stimulus first unlocks, then applies the disturbing access, and only then reads the data port. A returned register value, rather than 0xFF, shows that the flag survived. A register-file model with an address-dependent value makes a stale index visible in that same read.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_INDEX = 2'd1,
    SEL_KEY   = 2'd2,
    SEL_DATA  = 2'd3
  } port_sel_e;

  localparam int NUM_PORTS = 3;

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_port_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] BASE   = 16'h0022
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel
);

  logic [NUM_PORTS-1:0] hit;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(BASE) + ADDR_W'(g);
    assign hit[g] = (addr == PORT_ADDR);
  end

  always_comb begin
    sel = SEL_NONE;
    if (hit[0])      sel = SEL_INDEX;
    else if (hit[1]) sel = SEL_KEY;
    else if (hit[2]) sel = SEL_DATA;
  end

endmodule

// File: rtl/cfg_port_index.sv
module cfg_port_index #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

endmodule

// File: rtl/cfg_port_arm.sv
module cfg_port_arm #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  input  logic [DATA_W-1:0] idx,
  input  logic              consume,
  output logic              armed
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] expect_key;
  logic              key_ok;

  assign expect_key = {idx[HALF-1:0], idx[DATA_W-1:HALF]};
  assign key_ok     = key_wr && (key_val == expect_key);

  always_ff @(posedge clk) begin
    if (rst)          armed <= 1'b0;
    else if (key_ok)  armed <= 1'b1;
    else if (consume) armed <= 1'b0;
  end

endmodule

// File: rtl/cfg_port_rdmux.sv
module cfg_port_rdmux
  import cfg_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  port_sel_e         sel,
  input  logic [DATA_W-1:0] idx,
  input  logic              armed,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int HALF = DATA_W / 2;

  always_comb begin
    unique case (sel)
      SEL_INDEX: rdata = idx;
      SEL_KEY:   rdata = {idx[HALF-1:0], idx[DATA_W-1:HALF]};
      SEL_DATA:  rdata = armed ? rf_rdata : '1;
      default:   rdata = '1;
    endcase
  end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 8,
  parameter logic [15:0] BASE   = 16'h0022
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_rdata
);

  port_sel_e         sel;
  logic [DATA_W-1:0] idx_q;
  logic              armed_q;
  logic              idx_load;
  logic              key_wr;
  logic              consume;

  cfg_port_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr (io_addr),
    .sel  (sel)
  );

  assign idx_load = io_wr && (sel == SEL_INDEX);
  assign key_wr   = io_wr && (sel == SEL_KEY);
  assign consume  = (io_wr || io_rd) && (sel == SEL_DATA);

  cfg_port_index #(.DATA_W(DATA_W)) u_idx (
    .clk  (clk),
    .rst  (rst),
    .load (idx_load),
    .din  (io_wdata),
    .q    (idx_q)
  );

  cfg_port_arm #(.DATA_W(DATA_W)) u_arm (
    .clk     (clk),
    .rst     (rst),
    .key_wr  (key_wr),
    .key_val (io_wdata),
    .idx     (idx_q),
    .consume (consume),
    .armed   (armed_q)
  );

  cfg_port_rdmux #(.DATA_W(DATA_W)) u_mux (
    .sel      (sel),
    .idx      (idx_q),
    .armed    (armed_q),
    .rf_rdata (rf_rdata),
    .rdata    (io_rdata)
  );

  assign rf_addr = idx_q;

endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 8,
  parameter logic [15:0] BASE   = 16'h0022
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic [DATA_W-1:0] io_wdata,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_rdata,
  input logic [DATA_W-1:0] rf_addr,
  input logic [DATA_W-1:0] rf_rdata,
  input logic              armed
);

  localparam int HALF = DATA_W / 2;
  localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(BASE) + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(BASE) + ADDR_W'(2);

  logic [DATA_W-1:0] swapped;
  logic              in_window;
  assign swapped   = {rf_addr[HALF-1:0], rf_addr[DATA_W-1:HALF]};
  assign in_window = (io_addr == A_IDX) || (io_addr == A_KEY) || (io_addr == A_DAT);

  p_index_load_r1: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == A_IDX) |=> rf_addr == $past(io_wdata));

  p_index_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr == A_IDX) |=> $stable(rf_addr));

  p_key_arm_r2: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == A_KEY && io_wdata == swapped) |=> armed);

  p_key_miss_r2: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == A_KEY && io_wdata != swapped) |=> armed == $past(armed));

  p_key_read_r3: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == A_KEY) |-> io_rdata == swapped);

  p_data_read_r4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == A_DAT && armed) |-> io_rdata == rf_rdata);

  p_consume_r4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == A_DAT) |=> !armed);

  p_locked_ff_r5: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == A_DAT && !armed) |-> io_rdata == '1);

  p_data_wr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == A_DAT) |=> !armed);

  p_outside_ff_r7: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !in_window) |-> io_rdata == '1);

  p_outside_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((io_wr || io_rd) && !in_window) |=> armed == $past(armed));

endmodule

bind cfg_index_port cfg_index_port_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BASE   (BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_addr  (io_addr),
  .io_wr    (io_wr),
  .io_wdata (io_wdata),
  .io_rd    (io_rd),
  .io_rdata (io_rdata),
  .rf_addr  (rf_addr),
  .rf_rdata (rf_rdata),
  .armed    (armed_q)
);

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [15:0] P_IDX = 16'h0022;
  localparam logic [15:0] P_KEY = 16'h0023;
  localparam logic [15:0] P_DAT = 16'h0024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] io_addr = '0;
  logic              io_wr = 1'b0;
  logic [DATA_W-1:0] io_wdata = '0;
  logic              io_rd = 1'b0;
  logic [DATA_W-1:0] io_rdata;
  logic [DATA_W-1:0] rf_addr;
  logic [DATA_W-1:0] rf_rdata;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] idx_m = 8'h00;
  logic       armed_m = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rf_model(logic [7:0] a);
    return (a ^ 8'h3C) + 8'h11;
  endfunction

  function automatic logic [7:0] swap(logic [7:0] v);
    return {v[3:0], v[7:4]};
  endfunction

  assign rf_rdata = rf_model(rf_addr);

  cfg_index_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(16'h0022)) u_cfg_index_port (
    .clk, .rst, .io_addr, .io_wr, .io_wdata, .io_rd, .io_rdata, .rf_addr, .rf_rdata
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares every sampled read against the scoreboard
  always @(negedge clk) begin
    if (io_rd) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual %02h expected none", io_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(io_rdata, e.exp, e.tag);
      end
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
    if (a == P_IDX) idx_m = d;
    else if (a == P_KEY) begin
      if (d == swap(idx_m)) armed_m = 1'b1;
    end else if (a == P_DAT) armed_m = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input string tag);
    exp_t e;
    e.tag = tag;
    if (a == P_IDX)      e.exp = idx_m;
    else if (a == P_KEY) e.exp = swap(idx_m);
    else if (a == P_DAT) e.exp = armed_m ? rf_model(idx_m) : 8'hFF;
    else                 e.exp = 8'hFF;
    sb.push_back(e);
    @(posedge clk); #1;
    io_addr = a; io_rd = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0;
    if (a == P_DAT) armed_m = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R8: reset state
    check(rf_addr, 8'h00, "R8 rf_addr after reset");
    io_read(P_IDX, "R8 index after reset");
    io_read(P_DAT, "R8 locked after reset");

    // R1, R3: index store and swapped readback
    io_write(P_IDX, 8'hA5);
    check(rf_addr, 8'hA5, "R1 rf_addr follows index");
    io_read(P_IDX, "R1 index readback");
    io_read(P_KEY, "R3 swapped index");

    // R5: locked data read
    io_read(P_DAT, "R5 locked data read");

    // R2: wrong key does not unlock
    io_write(P_KEY, 8'hA5);
    io_read(P_DAT, "R2 wrong key keeps lock");

    // R4: correct key unlocks one read
    io_write(P_KEY, 8'h5A);
    io_read(P_DAT, "R4 unlocked data read");
    io_read(P_DAT, "R4 second read locked");

    // R2: wrong key while unlocked keeps unlock
    io_write(P_KEY, 8'h5A);
    io_write(P_KEY, 8'h00);
    io_read(P_DAT, "R2 wrong key keeps unlock");

    // R6: data write clears unlock, index kept
    io_write(P_KEY, 8'h5A);
    io_write(P_DAT, 8'h77);
    io_read(P_DAT, "R6 data write relocks");
    io_read(P_IDX, "R6 index unchanged");

    // R9: new index after key keeps unlock and selects new register
    io_write(P_KEY, 8'h5A);
    io_write(P_IDX, 8'h3C);
    io_read(P_DAT, "R9 unlock survives index write");

    // R7: outside addresses
    io_read(16'h0021, "R7 below window");
    io_read(16'h0025, "R7 above window");
    io_read(16'h0122, "R7 alias high byte");
    io_write(P_KEY, 8'hC3);
    io_write(16'h0025, 8'h11);
    io_write(16'h0122, 8'h99);
    io_read(P_IDX, "R7 outside write keeps index");
    io_read(P_DAT, "R7 outside write keeps unlock");

    // R2/R3: symmetric index, key equals index
    io_write(P_IDX, 8'h77);
    io_read(P_KEY, "R3 symmetric swap");
    io_write(P_KEY, 8'h77);
    io_read(P_DAT, "R2 symmetric key unlocks");

    // R8: reset while unlocked
    io_write(P_IDX, 8'hF0);
    io_write(P_KEY, 8'h0F);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    idx_m = 8'h00; armed_m = 1'b0;
    check(rf_addr, 8'h00, "R8 rf_addr after mid reset");
    io_read(P_DAT, "R8 reset clears unlock");
    io_read(P_IDX, "R8 reset clears index");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover actual %0d expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule